// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of one SPI channel from the functional clock, nominally 48 MHz. A granularity select chooses between two ways of reading the divider settings. In the coarse mode a 4-bit code selects a power-of-two half-period. In the fine mode a 12-bit linear half-period is formed: an 8-bit extension code supplies the upper bits and the 4-bit code supplies the low bits. Every half-period of SCLK lasts the selected number of functional-clock cycles, so one SCLK period lasts twice that number.

Next to the SCLK level, the block gives the shift logic one-cycle strobes. A leading-edge strobe and a trailing-edge strobe mark the two SCLK edges of each period. A sample strobe and a shift strobe take one of those two edges each, chosen by the phase input. The polarity input sets the level SCLK rests at. The shift logic enables the channel for the length of a transfer. While the channel is disabled, SCLK rests at its idle level. Divider changes made during a transfer are held back until the current SCLK period is complete.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `fine_gran` = 0, each SCLK half-period lasts 2^`div_code` functional-clock cycles (codes 0..15 give 1..32768).
- R2: With `fine_gran` = 1, each SCLK half-period lasts V cycles, where V = `ext_code` * 16 + `div_code` (`ext_code` in bits 11:4, `div_code` in bits 3:0).
- R3: With `fine_gran` = 1 and V = 0, the half-period is 1 cycle, so SCLK keeps running.
- R4: SCLK equals `cpol` while idle. The leading edge drives SCLK to the inverse of `cpol` and the trailing edge drives it back to `cpol`.
- R5: `lead_stb` and `trail_stb` are each high for exactly one cycle per SCLK period. Each one is high in the same cycle that SCLK first shows its new level, and the two are never high together.
- R6: With `cpha` = 0, `sample_stb` coincides with `lead_stb` and `shift_stb` coincides with `trail_stb`. With `cpha` = 1 the two roles are swapped.
- R7: A change of `fine_gran`, `div_code` or `ext_code` made while the channel runs first takes effect on the half-period that follows the next trailing edge.
- R8: When `chan_en` is low, SCLK shows `cpol` one cycle later, all strobes are low and the count is held at zero. After `chan_en` rises, the first leading edge appears exactly one half-period (L cycles) after the first rising clock edge that samples `chan_en` high.
- R9: After reset, SCLK equals `cpol` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low holds SCLK idle |
| fine_gran | input | 1 | 0: power-of-two mode, 1: linear mode |
| div_code | input | DIV_W | Divider code (exponent or low bits) |
| ext_code | input | EXT_W | Upper bits of the linear divisor |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sclk | output | 1 | Serial clock level |
| lead_stb | output | 1 | One-cycle pulse at the leading SCLK edge |
| trail_stb | output | 1 | One-cycle pulse at the trailing SCLK edge |
| sample_stb | output | 1 | One-cycle pulse at the edge where data is sampled |
| shift_stb | output | 1 | One-cycle pulse at the edge where data is launched |

## Verification
A wrong count or a divisor loaded at the wrong time shows up at the next strobe: the number of cycles between `lead_stb` and `trail_stb` no longer matches the half-period computed from the inputs. A wrong edge-level register shows up as SCLK at the wrong level in the same cycle as a strobe, or as a swapped sample/shift role. A counter that is not held at zero while disabled moves the first leading edge away from exactly L cycles after enable. The sweeps cover every coarse code up to 12, code 15, every fine low-bit code and several extension values.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    GRAN_POW2   = 1'b0,
    GRAN_LINEAR = 1'b1
  } gran_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclk_ratio_decode.sv
module sclk_ratio_decode
  import sclk_div_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int EXT_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             fine_gran,
  input  logic [DIV_W-1:0] div_code,
  input  logic [EXT_W-1:0] ext_code,
  output logic [CNT_W-1:0] half_cnt
);

  localparam int LIN_W = DIV_W + EXT_W;

  logic [LIN_W-1:0] lin_val;
  logic [CNT_W-1:0] pow_val;
  logic [CNT_W-1:0] lin_ext;

  assign lin_val = {ext_code, div_code};
  assign pow_val = CNT_W'(1) << div_code;

  generate
    if (CNT_W > LIN_W) begin : g_pad
      assign lin_ext = {{(CNT_W-LIN_W){1'b0}}, lin_val};
    end else begin : g_direct
      assign lin_ext = lin_val[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (gran_mode_e'(fine_gran))
      GRAN_POW2:   half_cnt = pow_val;
      GRAN_LINEAR: half_cnt = (lin_val == '0) ? CNT_W'(1) : lin_ext;
      default:     half_cnt = CNT_W'(1);
    endcase
  end

  // R3: the decoded half-period is never zero
  always_comb begin
    p_nonzero_half_r3: assert (half_cnt != '0);
  end

endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic [CNT_W-1:0] half_cnt,
  input  logic             period_end,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign wrap = chan_en && (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      cnt_q <= '0;
      lim_q <= half_cnt;
    end else if (wrap) begin
      cnt_q <= '0;
      if (period_end) lim_q <= half_cnt;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    chan_en |-> (cnt_q < lim_q));

  p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!chan_en) |-> (cnt_q == '0));

  p_lim_stable_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(chan_en) && !$past(period_end)) |-> (lim_q == $past(lim_q)));

endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic chan_en,
  input  logic cpol,
  input  logic cpha,
  input  logic wrap,
  output logic period_end,
  output logic sclk,
  output logic lead_stb,
  output logic trail_stb,
  output logic sample_stb,
  output logic shift_stb
);

  logic lvl_q;

  assign period_end = wrap && lvl_q;

  always_ff @(posedge clk) begin
    if (rst || !chan_en) begin
      lvl_q      <= 1'b0;
      sclk       <= cpol;
      lead_stb   <= 1'b0;
      trail_stb  <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      lead_stb   <= wrap && !lvl_q;
      trail_stb  <= wrap && lvl_q;
      sample_stb <= wrap && (lvl_q == cpha);
      shift_stb  <= wrap && (lvl_q != cpha);
      if (wrap) lvl_q <= ~lvl_q;
      sclk <= cpol ^ (wrap ? ~lvl_q : lvl_q);
    end
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_stb, trail_stb}));

  p_lead_level_r4: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> lvl_q);

  p_trail_level_r4: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> !lvl_q);

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!chan_en) |-> ((sclk == $past(cpol)) && !lead_stb && !trail_stb));

  p_phase_roles_r6: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || shift_stb) |-> (lead_stb || trail_stb));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             fine_gran,
  input  logic [DIV_W-1:0] div_code,
  input  logic [EXT_W-1:0] ext_code,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb,
  output logic             sample_stb,
  output logic             shift_stb
);

  // Wide enough for 2^(2^DIV_W - 1) and for the linear divisor
  localparam int CNT_W = max_int(1 << DIV_W, DIV_W + EXT_W);

  logic [CNT_W-1:0] half_cnt;
  logic             wrap;
  logic             period_end;

  sclk_ratio_decode #(
    .DIV_W (DIV_W),
    .EXT_W (EXT_W),
    .CNT_W (CNT_W)
  ) u_decode (
    .fine_gran (fine_gran),
    .div_code  (div_code),
    .ext_code  (ext_code),
    .half_cnt  (half_cnt)
  );

  sclk_half_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .half_cnt   (half_cnt),
    .period_end (period_end),
    .wrap       (wrap)
  );

  sclk_edge_gen u_edges (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .cpol       (cpol),
    .cpha       (cpha),
    .wrap       (wrap),
    .period_end (period_end),
    .sclk       (sclk),
    .lead_stb   (lead_stb),
    .trail_stb  (trail_stb),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

endmodule

// File: tb/sim_spi_sclk_divider.sv
module sim_spi_sclk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chan_en = 1'b0;
  logic       fine_gran = 1'b0;
  logic [3:0] div_code = '0;
  logic [7:0] ext_code = '0;
  logic       cpol = 1'b1;
  logic       cpha = 1'b0;
  logic       sclk, lead_stb, trail_stb, sample_stb, shift_stb;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_sclk_divider u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .fine_gran(fine_gran),
    .div_code(div_code), .ext_code(ext_code), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_for(input bit want_lead, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_lead ? lead_stb : trail_stb) && n < 70000);
  endtask

  function automatic int exp_half(input bit f, input int d, input int e);
    int v;
    if (!f) return 1 << d;
    v = e * 16 + d;
    return (v == 0) ? 1 : v;
  endfunction

  // Program a setting while disabled, enable it and measure the edges.
  task automatic run_cfg(input bit f, input int d, input int e, input bit pol,
                         input bit pha, input bit full, input string req);
    int n;
    int l;
    l = exp_half(f, d, e);
    @(negedge clk);
    chan_en = 1'b0;
    fine_gran = f; div_code = 4'(d); ext_code = 8'(e); cpol = pol; cpha = pha;
    @(negedge clk);
    chk(sclk == pol, "R4 idle", int'(sclk), int'(pol));
    chan_en = 1'b1;
    wait_for(1'b1, n);
    chk(n == l, req, n, l);
    chk(sclk == !pol, "R4 lead level", int'(sclk), int'(!pol));
    chk(sample_stb == !pha && shift_stb == pha, "R6 lead roles",
        int'({sample_stb, shift_stb}), int'({!pha, pha}));
    if (full) begin
      wait_for(1'b0, n);
      chk(n == l, req, n, l);
      chk(sclk == pol, "R4 trail level", int'(sclk), int'(pol));
      chk(sample_stb == pha && shift_stb == !pha, "R6 trail roles",
          int'({sample_stb, shift_stb}), int'({pha, !pha}));
      wait_for(1'b1, n);
      chk(n == l, "R5 one lead per period", n, l);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(sclk == 1'b1, "R9 sclk", int'(sclk), 1);
    chk(!lead_stb && !trail_stb && !sample_stb && !shift_stb, "R9 strobes",
        int'({lead_stb, trail_stb, sample_stb, shift_stb}), 0);
    rst = 1'b0;

    // R1: coarse codes
    for (int d = 0; d <= 12; d++) run_cfg(1'b0, d, 0, 1'b0, 1'b0, 1'b1, "R1");
    run_cfg(1'b0, 15, 0, 1'b0, 1'b0, 1'b0, "R1 max");

    // R2 and R3: fine codes, zero maps to one
    run_cfg(1'b1, 0, 0, 1'b0, 1'b0, 1'b1, "R3");
    for (int d = 1; d < 16; d++) run_cfg(1'b1, d, 0, 1'b0, 1'b0, 1'b1, "R2");
    run_cfg(1'b1, 0, 1, 1'b0, 1'b0, 1'b1, "R2 ext");
    run_cfg(1'b1, 5, 3, 1'b1, 1'b0, 1'b1, "R2 ext");
    run_cfg(1'b1, 9, 128, 1'b0, 1'b1, 1'b1, "R2 ext");
    run_cfg(1'b1, 15, 255, 1'b1, 1'b1, 1'b0, "R2 max");

    // R4, R6: all polarity and phase combinations
    for (int m = 0; m < 4; m++) run_cfg(1'b0, 1, 0, m[1], m[0], 1'b1, "R6");

    // R7: change taken at period boundary only
    run_cfg(1'b1, 3, 0, 1'b0, 1'b0, 1'b0, "R7 start");
    div_code = 4'd7;
    wait_for(1'b0, n);
    chk(n == 3, "R7 old half kept", n, 3);
    wait_for(1'b1, n);
    chk(n == 7, "R7 new half", n, 7);
    wait_for(1'b0, n);
    chk(n == 7, "R7 new half", n, 7);

    // R8: disable mid-period, hold idle, re-enable timing
    run_cfg(1'b1, 6, 0, 1'b1, 1'b0, 1'b0, "R8 start");
    chan_en = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(sclk == 1'b1 && !lead_stb && !trail_stb, "R8 idle hold",
          int'({sclk, lead_stb, trail_stb}), 4);
    end
    chan_en = 1'b1;
    wait_for(1'b1, n);
    chk(n == 6, "R8 restart", n, 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule